// File: doc/BRIEF.md
# DMA Page Register Address Extender

This block sits next to a four-channel DMA controller that produces only 16-bit memory addresses, and widens each of its memory cycles to a 24-bit system address. Each channel has its own 8-bit page byte. The CPU reads and writes these page bytes over a 16-bit peripheral bus that has per-byte lane enables. The same bus decode passes a window of offsets straight through to the controller's own register port.

The block watches the controller's active-low acknowledge lines to learn which channel currently owns the bus. When the controller starts a memory read or write strobe, the block puts the owning channel's page byte above the controller's 16-bit address. It then runs the cycle against system memory with a request/ready handshake and returns completion to the controller. If no channel owns the bus, the cycle ends locally: a read returns 0xFF and a write is discarded. The controller's hold request is forwarded to the CPU as a halt.

Top module: `dma_page_ext`

## Requirements
- R1: After reset every page byte reads as zero, no channel owns the bus, `cpu_halt` is low and `mem_req` is low.
- R2: A peripheral write to word offset 0x80+n (n = 0..3) with `pb_be[0]` set stores `pb_wdata[7:0]` as the page byte of channel n. With `pb_be[0]` clear the write changes nothing.
- R3: A peripheral read is answered on `pb_rdata` one cycle after the access. A read of 0x80+n with `pb_be[0]` set returns `{8'h00, page}`. A read with `pb_be[0]` clear, or a read of any offset outside 0x00..0x0F and 0x80..0x83, returns 0xFFFF.
- R4: Offsets 0x00..0x0F with `pb_be[0]` set assert `dc_cs` in the same cycle, with `dc_addr` equal to the offset, `dc_wdata = pb_wdata[7:0]` and `dc_wr = pb_wr`. A read returns `{8'h00, dc_rdata}`. With `pb_be[0]` clear, `dc_cs` stays low.
- R5: A high-to-low change on `dack_n[n]` makes channel n the owner from the next cycle on. If several lines fall in the same cycle, the lowest-numbered one wins.
- R6: A low-to-high change on `dack_n[n]` clears ownership only if channel n is the owner. Releasing any other channel leaves the owner unchanged.
- R7: For an owned cycle, `mem_addr[23:16]` is the owner's page byte and `mem_addr[15:0]` is `dc_maddr`.
- R8: A strobe with no owner never raises `mem_req`. A read returns 0xFF on `dc_mrdata`, a write is discarded, and `dc_mrdy` pulses on the cycle after the strobe is seen.
- R9: `mem_req` and `mem_addr` stay constant until `mem_rdy` is seen. On that edge the read data is registered into `dc_mrdata` and `dc_mrdy` pulses for exactly one cycle. A write presents `dc_mwdata` on `mem_wdata` with `mem_we` high.
- R10: `cpu_halt` follows `dc_hrq` with a one-cycle delay.
- R11: The page byte is sampled on the edge where the strobe is accepted. A page write in that same cycle affects only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pb_sel | input | 1 | Peripheral access strobe, one cycle |
| pb_wr | input | 1 | 1 = write, 0 = read |
| pb_addr | input | 9 | Peripheral word offset |
| pb_wdata | input | 16 | Peripheral write data |
| pb_be | input | 2 | Byte-lane enables, bit 0 = low lane |
| pb_rdata | output | 16 | Registered read data |
| dc_cs | output | 1 | Controller register select |
| dc_wr | output | 1 | Controller register write |
| dc_addr | output | 4 | Controller register index |
| dc_wdata | output | 8 | Controller register write data |
| dc_rdata | input | 8 | Controller register read data |
| dack_n | input | 4 | Active-low channel acknowledges |
| dc_hrq | input | 1 | Controller hold request |
| cpu_halt | output | 1 | Halt to CPU |
| dc_memr | input | 1 | Controller memory read strobe |
| dc_memw | input | 1 | Controller memory write strobe |
| dc_maddr | input | 16 | Controller memory address |
| dc_mwdata | input | 8 | Controller memory write data |
| dc_mrdata | output | 8 | Memory read data to controller |
| dc_mrdy | output | 1 | Cycle completion pulse |
| mem_req | output | 1 | System memory request |
| mem_we | output | 1 | System memory write enable |
| mem_addr | output | 24 | System memory address |
| mem_wdata | output | 8 | System memory write data |
| mem_rdata | input | 8 | System memory read data |
| mem_rdy | input | 1 | System memory ready |

## Verification
A CPU write to a page register can land in the same cycle as the controller's memory strobe for the channel that owns that page. The bench provokes this by driving the page write and the read strobe on the same clock. It then requires the resulting memory address to carry the old page byte and the next DMA cycle to carry the new one. Acknowledge edges that coincide are also provoked: two lines falling together must select the lower channel, and a release of a non-owner must leave the owner in place.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;
  typedef enum logic [1:0] {
    BR_IDLE = 2'd0,
    BR_WAIT = 2'd1,
    BR_DONE = 2'd2
  } br_state_t;
endpackage

// File: rtl/page_regs.sv
module page_regs #(
  parameter int CH       = 4,
  parameter int PAGE_W   = 8,
  parameter int PB_AW    = 9,
  parameter int PB_DW    = 16,
  parameter int REG_BASE = 'h80,
  localparam int CH_W    = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [PB_AW-1:0]  addr,
  input  logic [PB_DW-1:0]  wdata,
  input  logic [1:0]        be,
  input  logic [CH_W-1:0]   dma_ch,
  output logic              hit,
  output logic [PAGE_W-1:0] rd_byte,
  output logic [PAGE_W-1:0] dma_page
);
  logic [CH-1:0][PAGE_W-1:0] pg;
  logic [PB_AW-1:0]          rel;
  logic [CH_W-1:0]           idx;

  assign rel = addr - PB_AW'(REG_BASE);
  assign hit = sel && (addr >= PB_AW'(REG_BASE)) && (rel < PB_AW'(CH));
  assign idx = rel[CH_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pg <= '0;
    end else if (hit && wr && be[0]) begin
      pg[idx] <= wdata[PAGE_W-1:0];
    end
  end

  assign rd_byte  = pg[idx];
  assign dma_page = pg[dma_ch];

  // R2
  lane_off_write_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && wr && !be[0]) |=> $stable(pg));
endmodule

// File: rtl/chan_track.sv
module chan_track #(
  parameter int CH   = 4,
  localparam int CH_W = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CH-1:0]   dack_n,
  output logic            own_vld,
  output logic [CH_W-1:0] own_ch
);
  logic [CH-1:0]   prev_n;
  logic [CH-1:0]   fall;
  logic [CH-1:0]   rise;
  logic [CH_W-1:0] low_fall;

  assign fall = prev_n & ~dack_n;
  assign rise = ~prev_n & dack_n;

  always_comb begin
    low_fall = '0;
    for (int i = CH - 1; i >= 0; i--) begin
      if (fall[i]) low_fall = CH_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_n  <= '1;
      own_vld <= 1'b0;
      own_ch  <= '0;
    end else begin
      prev_n <= dack_n;
      if (|fall) begin
        own_vld <= 1'b1;
        own_ch  <= low_fall;
      end else if (own_vld && rise[own_ch]) begin
        own_vld <= 1'b0;
      end
    end
  end

  // R5
  lowest_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (prev_n[0] && !dack_n[0]) |=> (own_vld && own_ch == '0));
  // R6
  other_release_chk: assert property (@(posedge clk) disable iff (rst)
    (own_vld && fall == '0 && rise != '0 && !rise[own_ch]) |=> (own_vld && $stable(own_ch)));
endmodule

// File: rtl/mem_bridge.sv
module mem_bridge
  import dma_page_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int CA_W   = 16,
  parameter int DW     = 8,
  localparam int MA_W  = PAGE_W + CA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              own_vld,
  input  logic [PAGE_W-1:0] page,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [CA_W-1:0]   c_addr,
  input  logic [DW-1:0]     c_wdata,
  output logic [DW-1:0]     c_rdata,
  output logic              c_rdy,
  output logic              m_req,
  output logic              m_we,
  output logic [MA_W-1:0]   m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic [DW-1:0]     m_rdata,
  input  logic              m_rdy
);
  br_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= BR_IDLE;
      c_rdata <= '1;
      c_rdy   <= 1'b0;
      m_req   <= 1'b0;
      m_we    <= 1'b0;
      m_addr  <= '0;
      m_wdata <= '0;
    end else begin
      unique case (st)
        BR_IDLE: begin
          c_rdy <= 1'b0;
          if (rd_stb || wr_stb) begin
            if (own_vld) begin
              m_req   <= 1'b1;
              m_we    <= wr_stb;
              m_addr  <= {page, c_addr};
              m_wdata <= c_wdata;
              st      <= BR_WAIT;
            end else begin
              c_rdata <= '1;
              c_rdy   <= 1'b1;
              st      <= BR_DONE;
            end
          end
        end
        BR_WAIT: begin
          if (m_rdy) begin
            m_req <= 1'b0;
            m_we  <= 1'b0;
            if (!m_we) c_rdata <= m_rdata;
            c_rdy <= 1'b1;
            st    <= BR_DONE;
          end
        end
        BR_DONE: begin
          c_rdy <= 1'b0;
          if (!rd_stb && !wr_stb) st <= BR_IDLE;
        end
        default: st <= BR_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_rdy) |=> (m_req && $stable(m_addr)));
  // R9
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    c_rdy |=> !c_rdy);
  // R8
  no_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (st == BR_IDLE && (rd_stb || wr_stb) && !own_vld) |=> (!m_req && c_rdy));
endmodule

// File: rtl/dma_page_ext.sv
module dma_page_ext #(
  parameter int CH       = 4,
  parameter int PAGE_W   = 8,
  parameter int CA_W     = 16,
  parameter int DW       = 8,
  parameter int PB_AW    = 9,
  parameter int PB_DW    = 16,
  parameter int REG_BASE = 'h80,
  parameter int CTL_SPAN = 16,
  localparam int CH_W    = (CH > 1) ? $clog2(CH) : 1,
  localparam int CTL_AW  = $clog2(CTL_SPAN),
  localparam int MA_W    = PAGE_W + CA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pb_sel,
  input  logic              pb_wr,
  input  logic [PB_AW-1:0]  pb_addr,
  input  logic [PB_DW-1:0]  pb_wdata,
  input  logic [1:0]        pb_be,
  output logic [PB_DW-1:0]  pb_rdata,
  output logic              dc_cs,
  output logic              dc_wr,
  output logic [CTL_AW-1:0] dc_addr,
  output logic [DW-1:0]     dc_wdata,
  input  logic [DW-1:0]     dc_rdata,
  input  logic [CH-1:0]     dack_n,
  input  logic              dc_hrq,
  output logic              cpu_halt,
  input  logic              dc_memr,
  input  logic              dc_memw,
  input  logic [CA_W-1:0]   dc_maddr,
  input  logic [DW-1:0]     dc_mwdata,
  output logic [DW-1:0]     dc_mrdata,
  output logic              dc_mrdy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MA_W-1:0]   mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_rdy
);
  logic              reg_hit;
  logic [PAGE_W-1:0] reg_byte;
  logic [PAGE_W-1:0] cur_page;
  logic              own_vld;
  logic [CH_W-1:0]   own_ch;
  logic              ctl_hit;

  page_regs #(
    .CH(CH), .PAGE_W(PAGE_W), .PB_AW(PB_AW), .PB_DW(PB_DW), .REG_BASE(REG_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .sel(pb_sel), .wr(pb_wr), .addr(pb_addr),
    .wdata(pb_wdata), .be(pb_be), .dma_ch(own_ch),
    .hit(reg_hit), .rd_byte(reg_byte), .dma_page(cur_page)
  );

  chan_track #(.CH(CH)) u_track (
    .clk(clk), .rst(rst), .dack_n(dack_n), .own_vld(own_vld), .own_ch(own_ch)
  );

  mem_bridge #(.PAGE_W(PAGE_W), .CA_W(CA_W), .DW(DW)) u_bridge (
    .clk(clk), .rst(rst), .own_vld(own_vld), .page(cur_page),
    .rd_stb(dc_memr), .wr_stb(dc_memw), .c_addr(dc_maddr), .c_wdata(dc_mwdata),
    .c_rdata(dc_mrdata), .c_rdy(dc_mrdy),
    .m_req(mem_req), .m_we(mem_we), .m_addr(mem_addr), .m_wdata(mem_wdata),
    .m_rdata(mem_rdata), .m_rdy(mem_rdy)
  );

  assign ctl_hit  = pb_sel && (pb_addr < PB_AW'(CTL_SPAN));
  assign dc_cs    = ctl_hit && pb_be[0];
  assign dc_wr    = pb_wr;
  assign dc_addr  = pb_addr[CTL_AW-1:0];
  assign dc_wdata = pb_wdata[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pb_rdata <= '1;
      cpu_halt <= 1'b0;
    end else begin
      cpu_halt <= dc_hrq;
      if (pb_sel && !pb_wr) begin
        if (ctl_hit && pb_be[0])      pb_rdata <= PB_DW'(dc_rdata);
        else if (reg_hit && pb_be[0]) pb_rdata <= PB_DW'(reg_byte);
        else                          pb_rdata <= '1;
      end
    end
  end

  // R3
  lane_off_read_chk: assert property (@(posedge clk) disable iff (rst)
    (pb_sel && !pb_wr && !pb_be[0]) |=> (pb_rdata == '1));
  // R10
  halt_on_chk: assert property (@(posedge clk) disable iff (rst)
    dc_hrq |=> cpu_halt);
  // R10
  halt_off_chk: assert property (@(posedge clk) disable iff (rst)
    !dc_hrq |=> !cpu_halt);
endmodule

// File: tb/dma_page_ext_tb.sv
module dma_page_ext_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pb_sel = 0, pb_wr = 0;
  logic [8:0]  pb_addr = '0;
  logic [15:0] pb_wdata = '0;
  logic [1:0]  pb_be = '0;
  logic [15:0] pb_rdata;
  logic        dc_cs, dc_wr;
  logic [3:0]  dc_addr;
  logic [7:0]  dc_wdata, dc_rdata;
  logic [3:0]  dack_n = 4'hF;
  logic        dc_hrq = 0, cpu_halt;
  logic        dc_memr = 0, dc_memw = 0;
  logic [15:0] dc_maddr = '0;
  logic [7:0]  dc_mwdata = '0, dc_mrdata;
  logic        dc_mrdy, mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_rdy = 0;

  int checks = 0, errors = 0;
  bit finished = 0;
  int req_cnt = 0, req_seen = 0, wcount = 0;
  bit addr_moved = 0;
  logic [23:0] held_addr = '0, last_req_addr = '0, last_waddr = '0;
  logic [7:0]  last_wdata = '0;
  localparam int MEM_LAT = 3;

  always #2 clk = ~clk;

  assign dc_rdata = {4'h5, dc_addr};

  dma_page_ext u_dut (
    .clk(clk), .rst(rst), .pb_sel(pb_sel), .pb_wr(pb_wr), .pb_addr(pb_addr),
    .pb_wdata(pb_wdata), .pb_be(pb_be), .pb_rdata(pb_rdata),
    .dc_cs(dc_cs), .dc_wr(dc_wr), .dc_addr(dc_addr), .dc_wdata(dc_wdata),
    .dc_rdata(dc_rdata), .dack_n(dack_n), .dc_hrq(dc_hrq), .cpu_halt(cpu_halt),
    .dc_memr(dc_memr), .dc_memw(dc_memw), .dc_maddr(dc_maddr),
    .dc_mwdata(dc_mwdata), .dc_mrdata(dc_mrdata), .dc_mrdy(dc_mrdy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
  );

  // memory model: ready after MEM_LAT cycles of request
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_rdy) begin
        if (req_cnt > 0 && mem_addr != held_addr) addr_moved = 1;
        if (req_cnt == 0) req_seen++;
        held_addr = mem_addr;
        last_req_addr = mem_addr;
        req_cnt++;
        if (req_cnt == MEM_LAT) begin
          mem_rdy = 1;
          mem_rdata = mem_addr[7:0] ^ mem_addr[23:16];
          if (mem_we) begin
            wcount++;
            last_waddr = mem_addr;
            last_wdata = mem_wdata;
          end
        end
      end else begin
        mem_rdy = 0;
        req_cnt = 0;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pb_xfer(input bit wr, input logic [8:0] a, input logic [15:0] d,
                         input logic [1:0] be, output logic [15:0] rd);
    @(negedge clk);
    pb_sel = 1; pb_wr = wr; pb_addr = a; pb_wdata = d; pb_be = be;
    @(negedge clk);
    pb_sel = 0; pb_wr = 0;
    rd = pb_rdata;
  endtask

  task automatic dma_start(input bit wr, input logic [15:0] a, input logic [7:0] d);
    dc_maddr = a; dc_mwdata = d;
    if (wr) dc_memw = 1; else dc_memr = 1;
  endtask

  task automatic dma_finish(output logic [7:0] rd);
    int n = 0;
    @(negedge clk);
    while (!dc_mrdy && n < 50) begin
      @(negedge clk);
      n++;
    end
    rd = dc_mrdata;
    dc_memr = 0; dc_memw = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic dma_cycle(input bit wr, input logic [15:0] a, input logic [7:0] d,
                           output logic [7:0] rd);
    @(negedge clk);
    dma_start(wr, a, d);
    dma_finish(rd);
  endtask

  task automatic set_dack(input logic [3:0] v);
    @(negedge clk);
    dack_n = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] r;
    logic [7:0]  b;
    int s;
    chk("R1 halt", cpu_halt, 0);
    chk("R1 mem_req", mem_req, 0);
    for (int i = 0; i < 4; i++) begin
      pb_xfer(0, 9'h080 + 9'(i), 16'h0, 2'b11, r);
      chk("R1 page zero", r, 16'h0000);
    end
    s = req_seen;
    dma_cycle(0, 16'h1111, 8'h0, b);
    chk("R1 R8 no owner read", b, 8'hFF);
    chk("R8 no request", req_seen, s);
  endtask

  task automatic t_regs();
    logic [15:0] r;
    for (int i = 0; i < 4; i++) pb_xfer(1, 9'h080 + 9'(i), 16'h12A0 + 16'(i), 2'b11, r);
    for (int i = 0; i < 4; i++) begin
      pb_xfer(0, 9'h080 + 9'(i), 16'h0, 2'b11, r);
      chk("R2 R3 page readback", r, 16'h00A0 + 16'(i));
    end
    pb_xfer(1, 9'h081, 16'h0055, 2'b10, r);
    pb_xfer(0, 9'h081, 16'h0, 2'b01, r);
    chk("R2 lane-off write ignored", r, 16'h00A1);
    pb_xfer(0, 9'h082, 16'h0, 2'b10, r);
    chk("R3 lane-off read", r, 16'hFFFF);
    pb_xfer(0, 9'h100, 16'h0, 2'b11, r);
    chk("R3 unmapped read", r, 16'hFFFF);
    pb_xfer(0, 9'h084, 16'h0, 2'b11, r);
    chk("R3 past last page", r, 16'hFFFF);
  endtask

  task automatic t_ctl();
    logic [15:0] r;
    @(negedge clk);
    pb_sel = 1; pb_wr = 1; pb_addr = 9'h005; pb_wdata = 16'hBEEF; pb_be = 2'b01;
    #1;
    chk("R4 cs", dc_cs, 1);
    chk("R4 wr", dc_wr, 1);
    chk("R4 addr", dc_addr, 4'h5);
    chk("R4 wdata", dc_wdata, 8'hEF);
    @(negedge clk);
    pb_sel = 0; pb_wr = 0;
    pb_xfer(0, 9'h00A, 16'h0, 2'b01, r);
    chk("R4 ctl read", r, 16'h005A);
    @(negedge clk);
    pb_sel = 1; pb_wr = 0; pb_addr = 9'h00A; pb_be = 2'b10;
    #1;
    chk("R4 cs lane off", dc_cs, 0);
    @(negedge clk);
    pb_sel = 0;
    chk("R4 R3 ctl lane off read", pb_rdata, 16'hFFFF);
  endtask

  task automatic t_track();
    logic [7:0] b;
    int s;
    set_dack(4'b1011);
    dma_cycle(0, 16'h1234, 8'h0, b);
    chk("R5 R7 addr ch2", last_req_addr, 24'hA21234);
    chk("R9 read data", b, 8'h34 ^ 8'hA2);
    chk("R9 addr held", addr_moved, 0);
    set_dack(4'b1001);
    dma_cycle(0, 16'h0001, 8'h0, b);
    chk("R5 newest owner ch1", last_req_addr, 24'hA10001);
    set_dack(4'b1101);
    dma_cycle(0, 16'h0002, 8'h0, b);
    chk("R6 other release keeps owner", last_req_addr, 24'hA10002);
    set_dack(4'b1111);
    s = req_seen;
    dma_cycle(0, 16'h0003, 8'h0, b);
    chk("R6 R8 owner released", b, 8'hFF);
    chk("R6 R8 no request", req_seen, s);
    set_dack(4'b0110);
    dma_cycle(0, 16'h00C0, 8'h0, b);
    chk("R5 lowest of simultaneous", last_req_addr, 24'hA000C0);
    set_dack(4'b1111);
  endtask

  task automatic t_write();
    logic [7:0] b;
    int w;
    set_dack(4'b0111);
    w = wcount;
    dma_cycle(1, 16'h00FE, 8'h77, b);
    chk("R9 write count", wcount, w + 1);
    chk("R7 write addr", last_waddr, 24'hA300FE);
    chk("R9 write data", last_wdata, 8'h77);
    set_dack(4'b1111);
    w = wcount;
    dma_cycle(1, 16'h0010, 8'h99, b);
    chk("R8 write dropped", wcount, w);
  endtask

  task automatic t_hold();
    @(negedge clk); dc_hrq = 1;
    @(negedge clk);
    chk("R10 halt rise", cpu_halt, 1);
    dc_hrq = 0;
    @(negedge clk);
    chk("R10 halt fall", cpu_halt, 0);
  endtask

  task automatic t_race();
    logic [7:0]  b;
    set_dack(4'b1110);
    @(negedge clk);
    pb_sel = 1; pb_wr = 1; pb_addr = 9'h080; pb_wdata = 16'h00C0; pb_be = 2'b01;
    dma_start(0, 16'h4242, 8'h0);
    fork
      begin @(negedge clk); pb_sel = 0; pb_wr = 0; end
    join_none
    dma_finish(b);
    chk("R11 old page used", last_req_addr, 24'hA04242);
    dma_cycle(0, 16'h4243, 8'h0, b);
    chk("R11 new page later", last_req_addr, 24'hC04243);
    set_dack(4'b1111);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_ctl();
    t_track();
    t_write();
    t_hold();
    t_race();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule